// File: doc/BRIEF.md
# Sensor Command Register Port

This block is a command port for a small register file inside a sensor macro. The host writes one 32-bit command word. The word carries four fields: a program flag, a write/read select, a 3-bit register address and a 24-bit data field. An accepted command runs in the background for a programmable number of clock cycles and raises a busy status bit while it runs. When it completes, one of two things happens: a write stores the masked data into the addressed register, or a read copies the addressed register into a read-data register.

The register file holds five registers: control, configuration, data, channel poll and power-up timer. Each register keeps only its defined bits. The control register holds the reset-release bit, the continuous-run bit, the automatic-sequencing bit and the voltage-monitor bit. The reset-release bit also drives the lock status bit. The host must poll busy until it reads low before it issues the next command. A command written while busy is high is discarded and sets a sticky error bit. A status-read strobe from the host clears that bit.

Top module: `sensor_cmd_port`

## Requirements
- R1: After reset, busy, lock, error and rd_data read 0, and every register reads back as 0.
- R2: A command word is accepted only when bit 31 (program flag) is 1. A write strobe with bit 31 at 0 raises no busy, sets no error and changes no register.
- R3: Busy rises on the cycle after an accepted command. It stays high for exactly N cycles, where N is the value of lat_cycles sampled when the command is accepted, and a value of 0 counts as 1.
- R4: Bit 27 at 1 selects a write. When the command completes, the addressed register (bits 26:24) takes data bits 23:0 ANDed with that register's mask. The addresses and masks are: control = 0 with mask 0x00050A (bits 1, 3, 8, 10); configuration = 1 with mask 0x0000FF; data = 3 with mask 0x00FFFF; poll = 4 with mask 0x3FFFFF (bit 20 channel init, bit 21 channel request, bits 19:0 channel enables); timer = 5 with mask 0x00FFFF.
- R5: Bit 27 at 0 selects a read. The addressed register value is in rd_data by the first cycle busy reads low. rd_data changes only when a read completes.
- R6: Addresses 2, 6 and 7 are unmapped. Writes to them change nothing, and reads from them return 0.
- R7: A command with bit 31 at 1 written while busy is high is discarded. Its register does not change, and status bit 2 (error) is 1 on the next cycle.
- R8: The error bit stays set until a stat_re pulse clears it on the next cycle. If a discarded command and stat_re arrive in the same cycle, the error bit stays set.
- R9: Status bit 1 (lock) equals control register bit 1 (reset release). Status bit 0 is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Host write strobe for the command word |
| cmd_word | input | 32 | Command: program flag, write select, address, data |
| stat_re | input | 1 | Host status-read strobe; clears the error bit |
| lat_cycles | input | LAT_W | Command latency in cycles, sampled at accept |
| status | output | 3 | Bit 0 busy, bit 1 lock, bit 2 sticky error |
| rd_data | output | 24 | Value returned by the last completed read |

## Verification
The assertions assume the host holds lat_cycles steady only at the accept cycle and may raise cmd_we at any time. They also assume stat_re is a single-cycle pulse, but the properties remain valid if it is held longer. The stimulus drives every input at the falling edge. It waits for busy to read low before each normal command, and it breaks that rule only on purpose, to exercise the discard and sticky-error paths. The stimulus uses latencies of 0, 1 and larger values, so the busy-length and completion-timing properties are exercised at the counter boundary as well as in longer runs.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

    localparam int CMD_W  = 32;
    localparam int DATA_W = 24;
    localparam int ADDR_W = 3;
    localparam int N_SLV  = 1 << ADDR_W;
    localparam int STAT_W = 3;

    localparam int ST_BUSY = 0;
    localparam int ST_LOCK = 1;
    localparam int ST_ERR  = 2;

    localparam int CTRL_RST_REL = 1;
    localparam int CTRL_RUN     = 3;
    localparam int CTRL_AUTO    = 8;
    localparam int CTRL_VMON    = 10;

    typedef struct packed {
        logic              prog;
        logic [2:0]        rsv;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_word_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;

    typedef enum logic [ADDR_W-1:0] {
        SLV_CTRL = 3'd0,
        SLV_CFG  = 3'd1,
        SLV_DATA = 3'd3,
        SLV_POLL = 3'd4,
        SLV_TMR  = 3'd5
    } slave_e;

    localparam logic [DATA_W-1:0] CTRL_MASK =
        DATA_W'((1 << CTRL_RST_REL) | (1 << CTRL_RUN) |
                (1 << CTRL_AUTO) | (1 << CTRL_VMON));
    localparam logic [DATA_W-1:0] CFG_MASK  = 24'h0000FF;
    localparam logic [DATA_W-1:0] DATA_MASK = 24'h00FFFF;
    localparam logic [DATA_W-1:0] POLL_MASK = 24'h3FFFFF;
    localparam logic [DATA_W-1:0] TMR_MASK  = 24'h00FFFF;

    function automatic logic [DATA_W-1:0] slave_mask(input logic [ADDR_W-1:0] a);
        case (a)
            SLV_CTRL: return CTRL_MASK;
            SLV_CFG:  return CFG_MASK;
            SLV_DATA: return DATA_MASK;
            SLV_POLL: return POLL_MASK;
            SLV_TMR:  return TMR_MASK;
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/cmdp_sequencer.sv
module cmdp_sequencer
    import cmdp_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             stat_re,
    input  logic [LAT_W-1:0] lat_cycles,
    output logic             busy,
    output logic             err,
    output logic             done,
    output req_t             req
);

    cmd_word_t        cw;
    logic             accept;
    logic             drop;
    logic             busy_q;
    logic             err_q;
    logic [LAT_W-1:0] cnt_q;
    req_t             req_q;
    logic             unused_rsv;

    assign cw         = cmd_word_t'(cmd_word);
    assign unused_rsv = ^cw.rsv;
    assign accept     = cmd_we && cw.prog && !busy_q;
    assign drop       = cmd_we && cw.prog && busy_q;
    assign done       = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            req_q  <= '0;
        end else if (accept) begin
            busy_q     <= 1'b1;
            cnt_q      <= (lat_cycles == '0) ? '0 : lat_cycles - 1'b1;
            req_q.wr   <= cw.wr;
            req_q.addr <= cw.addr;
            req_q.data <= cw.data;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (drop) begin
            err_q <= 1'b1;
        end else if (stat_re) begin
            err_q <= 1'b0;
        end
    end

    assign busy = busy_q;
    assign err  = err_q;
    assign req  = req_q;

    // R3
    accept_raises_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_word[CMD_W-1] && !busy) |=> busy);

    // R2
    noprog_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !cmd_word[CMD_W-1] && !busy) |=> !busy);

    // R7
    drop_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_word[CMD_W-1] && busy) |=> err);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !stat_re) |=> err);

endmodule

// File: rtl/cmdp_slave_regs.sv
module cmdp_slave_regs
    import cmdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rvalue,
    output logic              rst_rel
);

    logic [DATA_W-1:0] slv_q [N_SLV];

    for (genvar g = 0; g < N_SLV; g++) begin : g_slv
        if (slave_mask(ADDR_W'(g)) != '0) begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_en && (addr == ADDR_W'(g))) begin
                    q <= wdata & slave_mask(ADDR_W'(g));
                end
            end
            assign slv_q[g] = q;
        end else begin : g_hole
            assign slv_q[g] = '0;
        end
    end

    assign rvalue  = slv_q[addr];
    assign rst_rel = slv_q[SLV_CTRL][CTRL_RST_REL];

endmodule

// File: rtl/sensor_cmd_port.sv
module sensor_cmd_port
    import cmdp_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              stat_re,
    input  logic [LAT_W-1:0]  lat_cycles,
    output logic [STAT_W-1:0] status,
    output logic [DATA_W-1:0] rd_data
);

    logic              busy;
    logic              err;
    logic              done;
    req_t              req;
    logic [DATA_W-1:0] rvalue;
    logic              lock;
    logic [DATA_W-1:0] rd_q;

    cmdp_sequencer #(.LAT_W(LAT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_we     (cmd_we),
        .cmd_word   (cmd_word),
        .stat_re    (stat_re),
        .lat_cycles (lat_cycles),
        .busy       (busy),
        .err        (err),
        .done       (done),
        .req        (req)
    );

    cmdp_slave_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (done && req.wr),
        .addr    (req.addr),
        .wdata   (req.data),
        .rvalue  (rvalue),
        .rst_rel (lock)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (done && !req.wr) begin
            rd_q <= rvalue;
        end
    end

    always_comb begin
        status          = '0;
        status[ST_BUSY] = busy;
        status[ST_LOCK] = lock;
        status[ST_ERR]  = err;
    end

    assign rd_data = rd_q;

    // R5
    rd_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(rd_data));

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(status[ST_LOCK]));

endmodule

// File: tb/sensor_cmd_port_bench.sv
module sensor_cmd_port_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        stat_re = 1'b0;
    logic [7:0]  lat_cycles = 8'd2;
    logic [2:0]  status;
    logic [23:0] rd_data;

    always #4 clk = ~clk;

    sensor_cmd_port u_sensor_cmd_port (
        .clk        (clk),
        .rst        (rst),
        .cmd_we     (cmd_we),
        .cmd_word   (cmd_word),
        .stat_re    (stat_re),
        .lat_cycles (lat_cycles),
        .status     (status),
        .rd_data    (rd_data)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [23:0] exp_q[$];
    logic [23:0] m_reg[8];
    logic [23:0] m_rd = '0;
    logic        busy_prev = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] bmask(input int a);
        case (a)
            0: return 24'h00050A;
            1: return 24'h0000FF;
            3: return 24'h00FFFF;
            4: return 24'h3FFFFF;
            5: return 24'h00FFFF;
            default: return 24'h0;
        endcase
    endfunction

    function automatic logic [31:0] mkcmd(input bit wr, input int a, input logic [23:0] d);
        return {1'b1, 3'b000, wr, 3'(a), d};
    endfunction

    // scoreboard monitor: every completion is compared with the model
    always @(negedge clk) begin
        if (!rst && busy_prev && !status[0]) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 completion without expectation", 32'(rd_data), 0);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R5 rd_data at completion", 32'(rd_data), 32'(e));
            end
        end
        busy_prev = status[0];
    end

    task automatic push_model(input logic [31:0] w);
        int a;
        a = int'(w[26:24]);
        if (w[27]) m_reg[a] = w[23:0] & bmask(a);
        else       m_rd = m_reg[a];
        exp_q.push_back(m_rd);
    endtask

    task automatic wait_idle();
        while (status[0]) @(negedge clk);
    endtask

    task automatic run_cmd(input logic [31:0] w, input int lat);
        int n;
        int exp_n;
        @(negedge clk);
        lat_cycles = 8'(lat);
        cmd_word   = w;
        cmd_we     = 1'b1;
        if (w[31]) push_model(w);
        @(negedge clk);
        cmd_we = 1'b0;
        n = 0;
        while (status[0]) begin
            n++;
            @(negedge clk);
        end
        exp_n = w[31] ? ((lat == 0) ? 1 : lat) : 0;
        if (w[31]) chk(n == exp_n, "R3 busy length", 32'(n), 32'(exp_n));
        else       chk(n == exp_n, "R2 no busy without program flag", 32'(n), 32'(exp_n));
    endtask

    task automatic read_chk(input int a, input logic [23:0] exp, input string tag);
        run_cmd(mkcmd(1'b0, a, 24'h0), 2);
        chk(rd_data == exp, tag, 32'(rd_data), 32'(exp));
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(status == 3'b000, "R1 status after reset", 32'(status), 0);
        chk(rd_data == 24'h0, "R1 rd_data after reset", 32'(rd_data), 0);
        for (int a = 0; a < 8; a++) read_chk(a, 24'h0, "R1 register reset value");

        // R4 R9: control write with every bit set keeps only defined bits
        run_cmd(mkcmd(1'b1, 0, 24'hFFFFFF), 3);
        chk(status[1] == 1'b1, "R9 lock follows reset release", 32'(status[1]), 1);
        read_chk(0, 24'h00050A, "R4 control mask");
        run_cmd(mkcmd(1'b1, 1, 24'hABCDEF), 1);
        read_chk(1, 24'h0000EF, "R4 config mask");
        run_cmd(mkcmd(1'b1, 4, 24'hFFFFFF), 4);
        read_chk(4, 24'h3FFFFF, "R4 poll mask");
        run_cmd(mkcmd(1'b1, 5, 24'h012345), 2);
        read_chk(5, 24'h002345, "R4 timer mask");
        run_cmd(mkcmd(1'b1, 3, 24'h01ABCD), 0);
        read_chk(3, 24'h00ABCD, "R4 data mask");

        // R5: a write leaves rd_data alone
        run_cmd(mkcmd(1'b1, 5, 24'h000777), 2);
        chk(rd_data == 24'h00ABCD, "R5 rd_data held over write", 32'(rd_data), 32'h00ABCD);

        // R6: unmapped addresses
        for (int a = 6; a < 8; a++) begin
            run_cmd(mkcmd(1'b1, a, 24'hFFFFFF), 1);
            read_chk(a, 24'h0, "R6 unmapped reads zero");
        end
        run_cmd(mkcmd(1'b1, 2, 24'h123456), 1);
        read_chk(2, 24'h0, "R6 unmapped address 2");
        read_chk(0, 24'h00050A, "R6 control untouched by unmapped write");

        // R2: no program flag
        run_cmd({1'b0, 3'b000, 1'b1, 3'd1, 24'h000055}, 2);
        chk(status[2] == 1'b0, "R2 no error without program flag", 32'(status[2]), 0);
        read_chk(1, 24'h0000EF, "R2 config unchanged");

        // R3: latency boundaries
        run_cmd(mkcmd(1'b1, 1, 24'h000011), 0);
        run_cmd(mkcmd(1'b1, 1, 24'h000012), 1);
        run_cmd(mkcmd(1'b1, 1, 24'h000013), 12);

        // R7: command while busy is dropped
        @(negedge clk);
        lat_cycles = 8'd6;
        cmd_word   = mkcmd(1'b1, 1, 24'h000021);
        cmd_we     = 1'b1;
        push_model(cmd_word);
        @(negedge clk);
        cmd_word = mkcmd(1'b1, 1, 24'h000077);
        cmd_we   = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(status[2] == 1'b1, "R7 error after dropped command", 32'(status[2]), 1);
        wait_idle();
        read_chk(1, 24'h000021, "R7 dropped write has no effect");
        chk(status[2] == 1'b1, "R8 error sticky", 32'(status[2]), 1);

        // R8: status read clears
        @(negedge clk);
        stat_re = 1'b1;
        @(negedge clk);
        stat_re = 1'b0;
        chk(status[2] == 1'b0, "R8 status read clears error", 32'(status[2]), 0);

        // R8: set wins over clear
        @(negedge clk);
        lat_cycles = 8'd4;
        cmd_word   = mkcmd(1'b1, 5, 24'h000042);
        cmd_we     = 1'b1;
        push_model(cmd_word);
        @(negedge clk);
        cmd_word = mkcmd(1'b1, 5, 24'h000099);
        stat_re  = 1'b1;
        @(negedge clk);
        cmd_we  = 1'b0;
        stat_re = 1'b0;
        chk(status[2] == 1'b1, "R8 drop beats clear", 32'(status[2]), 1);
        wait_idle();
        read_chk(5, 24'h000042, "R7 timer keeps first write");

        // R9: clearing reset release drops lock
        run_cmd(mkcmd(1'b1, 0, 24'h000508), 2);
        chk(status[1] == 1'b0, "R9 lock clears", 32'(status[1]), 0);
        read_chk(0, 24'h000508, "R4 control partial bits");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all completions seen", 32'(exp_q.size()), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule